// File: doc/BRIEF.md
# Virtual-Port Forwarding Table

This block is the address table of a small embedded switch whose ports are virtual. Vport 0 stands for the parent function. Vports 1 to N stand for child functions 0 to N-1. One more vport, the uplink, leads to the upstream function switch. A lookup presents a destination MAC address and the vport the frame came from. One clock later the block returns a destination bitmap with one bit per vport, and the uplink is the highest bit.

The table is fully associative and holds a parameterised number of rules. Each rule binds a 48-bit MAC either to exactly one vport (unicast) or to a non-empty set of vports (multicast). A multicast set may contain vport 0 and the uplink together. When no rule matches, a fixed fallback applies. Frames from any function go to the uplink, and frames from the uplink go to the parent function. The requesting vport is always removed from the returned bitmap.

Only the switch manager, the parent function, writes the table, through a management command port. An add, modify or delete command names its entry by MAC. Every command gets a status one clock later.

Top module: `vfdb_engine`

## Requirements
- R1: After synchronous reset, res_valid, res_hit, res_mcast, res_mask, mg_done and mg_status are all zero, and the table is empty, so any lookup misses, including a lookup of MAC 0.
- R2: A lookup accepted with lk_valid at a clock edge produces res_valid high for exactly the following cycle, and its result holds until the next lookup.
- R3: A lookup whose MAC equals a valid rule's MAC in all 48 bits returns res_hit=1, res_mcast equal to the rule's type, and the rule's mask with the source bit removed.
- R4: A missed lookup from a source vport in 0..N returns res_hit=0 and a mask with only bit N+1 (the uplink) set.
- R5: A missed lookup whose source is the uplink (lk_src = N+1) returns res_hit=0 and a mask with only bit 0 set.
- R6: Bit lk_src of the result is always zero. A unicast rule that points back at the requester therefore returns an all-zero mask with res_hit=1.
- R7: A multicast rule may hold several vports, including vport 0 and the uplink at the same time, and a hit returns all of them except the source.
- R8: Command codes are 0 add, 1 modify, 2 delete, and 3 reserved. Status codes are 0 done, 1 not found, 2 no room, and 3 rejected. mg_done pulses for one cycle after each command. An add of a MAC already present returns 3. An add of a well-formed new rule to a full table returns 2. Code 3 returns 3. None of these three cases changes the table.
- R9: A modify of a present MAC replaces its type and mask and returns 0. A modify of an absent MAC returns 1.
- R10: A delete of a present MAC removes it and returns 0, so later lookups of that MAC miss. A delete of an absent MAC returns 1.
- R11: An add or modify is rejected with status 3, leaving the table unchanged, when a unicast rule (mg_mcast=0) names other than exactly one vport or when a multicast rule names no vport.
- R12: When a lookup and a command touch the same MAC in the same cycle, the lookup result reflects the table as it stood before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_mac | input | 48 | Destination MAC to look up |
| lk_src | input | $clog2(NUM_CHILD+2) | Source vport, N+1 = uplink |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A rule matched |
| res_mcast | output | 1 | Matching rule is multicast |
| res_mask | output | NUM_CHILD+2 | Destination vport bitmap, bit N+1 = uplink |
| mg_valid | input | 1 | Management command strobe |
| mg_cmd | input | 2 | Command code |
| mg_mac | input | 48 | MAC that names the entry |
| mg_mcast | input | 1 | Rule type for add/modify |
| mg_mask | input | NUM_CHILD+2 | Destination set for add/modify |
| mg_done | output | 1 | Command completed |
| mg_status | output | 2 | Command status code |

## Verification
A lookup and a management command can arrive in the same cycle and name the same MAC. The bench presents both at the same clock edge, first an add of a new MAC and later a delete of that MAC. It expects the lookup to miss in the add case and to hit in the delete case, because each lookup reflects the table before that edge's write. A second lookup in the next cycle must show the new contents, and the command status checked in the same cycle must be done.

// File: rtl/vfdb_pkg.sv
package vfdb_pkg;

    localparam int MAC_W = 48;

    typedef logic [MAC_W-1:0] mac_t;

    typedef enum logic [1:0] {
        CMD_ADD = 2'd0,
        CMD_MOD = 2'd1,
        CMD_DEL = 2'd2,
        CMD_RSV = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_NOT_FOUND = 2'd1,
        ST_NO_ROOM   = 2'd2,
        ST_REJECT    = 2'd3
    } status_e;

    // Outcome of decoding one management command
    typedef struct packed {
        logic    wr;
        logic    keep;
        logic    use_free;
        status_e st;
    } decision_t;

endpackage

// File: rtl/vfdb_table.sv
module vfdb_table
    import vfdb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NP    = 6,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_keep,
    input  mac_t             wr_mac,
    input  logic             wr_mcast,
    input  logic [NP-1:0]    wr_mask,
    input  mac_t             lk_mac,
    output logic             lk_hit,
    output logic             lk_mcast,
    output logic [NP-1:0]    lk_mask,
    input  mac_t             mg_mac,
    output logic             mg_hit,
    output logic [IDX_W-1:0] mg_idx,
    output logic             free_ok,
    output logic [IDX_W-1:0] free_idx
);

    logic             vld_q   [DEPTH];
    mac_t             mac_q   [DEPTH];
    logic             mc_q    [DEPTH];
    logic [NP-1:0]    msk_q   [DEPTH];
    logic [DEPTH-1:0] lk_vec;
    logic [DEPTH-1:0] mg_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[g] <= 1'b0;
                mac_q[g] <= '0;
                mc_q[g]  <= 1'b0;
                msk_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                vld_q[g] <= wr_keep;
                mac_q[g] <= wr_mac;
                mc_q[g]  <= wr_mcast;
                msk_q[g] <= wr_mask;
            end
        end

        assign lk_vec[g] = vld_q[g] && (mac_q[g] == lk_mac);
        assign mg_vec[g] = vld_q[g] && (mac_q[g] == mg_mac);
    end

    // Entries are unique by MAC, so an OR of the selected fields is a mux
    always_comb begin
        lk_mask  = '0;
        lk_mcast = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (lk_vec[i]) begin
                lk_mask  = lk_mask | msk_q[i];
                lk_mcast = lk_mcast | mc_q[i];
            end
        end
    end

    assign lk_hit = |lk_vec;
    assign mg_hit = |mg_vec;

    always_comb begin
        mg_idx   = '0;
        free_idx = '0;
        free_ok  = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (mg_vec[i]) begin
                mg_idx = IDX_W'(i);
            end
            if (!vld_q[i]) begin
                free_idx = IDX_W'(i);
                free_ok  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vfdb_ctrl.sv
module vfdb_ctrl
    import vfdb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NP    = 6,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mg_valid,
    input  logic [1:0]       mg_cmd,
    input  logic             mg_mcast,
    input  logic [NP-1:0]    mg_mask,
    input  logic             mg_hit,
    input  logic [IDX_W-1:0] mg_idx,
    input  logic             free_ok,
    input  logic [IDX_W-1:0] free_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             wr_keep,
    output logic             mg_done,
    output logic [1:0]       mg_status
);

    cmd_e      cmd;
    decision_t dec;
    logic      one_bit;
    logic      shape_ok;

    assign cmd      = cmd_e'(mg_cmd);
    assign one_bit  = (mg_mask != '0) && ((mg_mask & (mg_mask - NP'(1))) == '0);
    assign shape_ok = mg_mcast ? (mg_mask != '0) : one_bit;

    always_comb begin
        dec = '{wr: 1'b0, keep: 1'b0, use_free: 1'b0, st: ST_REJECT};
        unique case (cmd)
            CMD_ADD: begin
                if (mg_hit || !shape_ok) begin
                    dec.st = ST_REJECT;
                end else if (!free_ok) begin
                    dec.st = ST_NO_ROOM;
                end else begin
                    dec = '{wr: 1'b1, keep: 1'b1, use_free: 1'b1, st: ST_OK};
                end
            end
            CMD_MOD: begin
                if (!mg_hit) begin
                    dec.st = ST_NOT_FOUND;
                end else if (!shape_ok) begin
                    dec.st = ST_REJECT;
                end else begin
                    dec = '{wr: 1'b1, keep: 1'b1, use_free: 1'b0, st: ST_OK};
                end
            end
            CMD_DEL: begin
                if (!mg_hit) begin
                    dec.st = ST_NOT_FOUND;
                end else begin
                    dec = '{wr: 1'b1, keep: 1'b0, use_free: 1'b0, st: ST_OK};
                end
            end
            default: dec.st = ST_REJECT;
        endcase
    end

    assign wr_en   = mg_valid && dec.wr;
    assign wr_idx  = dec.use_free ? free_idx : mg_idx;
    assign wr_keep = dec.keep;

    always_ff @(posedge clk) begin
        if (rst) begin
            mg_done   <= 1'b0;
            mg_status <= ST_OK;
        end else begin
            mg_done   <= mg_valid;
            mg_status <= mg_valid ? dec.st : ST_OK;
        end
    end

endmodule

// File: rtl/vfdb_resolve.sv
module vfdb_resolve #(
    parameter int NP    = 6,
    localparam int SRC_W  = $clog2(NP),
    localparam int UPLINK = NP - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [SRC_W-1:0] lk_src,
    input  logic             tbl_hit,
    input  logic             tbl_mcast,
    input  logic [NP-1:0]    tbl_mask,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_mcast,
    output logic [NP-1:0]    res_mask
);

    logic [NP-1:0] base;
    logic [NP-1:0] src_bit;

    // Fallback when nothing matched: uplink traffic to the parent, rest upward
    always_comb begin
        if (tbl_hit) begin
            base = tbl_mask;
        end else if (lk_src == SRC_W'(UPLINK)) begin
            base = NP'(1);
        end else begin
            base = NP'(1) << UPLINK;
        end
    end

    always_comb begin
        src_bit = '0;
        for (int i = 0; i < NP; i++) begin
            src_bit[i] = (lk_src == SRC_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_mcast <= 1'b0;
            res_mask  <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_hit   <= tbl_hit;
                res_mcast <= tbl_hit && tbl_mcast;
                res_mask  <= base & ~src_bit;
            end
        end
    end

endmodule

// File: rtl/vfdb_engine.sv
module vfdb_engine
    import vfdb_pkg::*;
#(
    parameter int NUM_CHILD = 4,
    parameter int DEPTH     = 8,
    localparam int NP    = NUM_CHILD + 2,
    localparam int SRC_W = $clog2(NP),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [47:0]      lk_mac,
    input  logic [SRC_W-1:0] lk_src,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_mcast,
    output logic [NP-1:0]    res_mask,
    input  logic             mg_valid,
    input  logic [1:0]       mg_cmd,
    input  logic [47:0]      mg_mac,
    input  logic             mg_mcast,
    input  logic [NP-1:0]    mg_mask,
    output logic             mg_done,
    output logic [1:0]       mg_status
);

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_keep;
    logic             t_hit;
    logic             t_mcast;
    logic [NP-1:0]    t_mask;
    logic             m_hit;
    logic [IDX_W-1:0] m_idx;
    logic             f_ok;
    logic [IDX_W-1:0] f_idx;

    vfdb_table #(.DEPTH(DEPTH), .NP(NP)) i_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_keep  (wr_keep),
        .wr_mac   (mg_mac),
        .wr_mcast (mg_mcast),
        .wr_mask  (mg_mask),
        .lk_mac   (lk_mac),
        .lk_hit   (t_hit),
        .lk_mcast (t_mcast),
        .lk_mask  (t_mask),
        .mg_mac   (mg_mac),
        .mg_hit   (m_hit),
        .mg_idx   (m_idx),
        .free_ok  (f_ok),
        .free_idx (f_idx)
    );

    vfdb_ctrl #(.DEPTH(DEPTH), .NP(NP)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mg_valid  (mg_valid),
        .mg_cmd    (mg_cmd),
        .mg_mcast  (mg_mcast),
        .mg_mask   (mg_mask),
        .mg_hit    (m_hit),
        .mg_idx    (m_idx),
        .free_ok   (f_ok),
        .free_idx  (f_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_keep   (wr_keep),
        .mg_done   (mg_done),
        .mg_status (mg_status)
    );

    vfdb_resolve #(.NP(NP)) i_resolve (
        .clk       (clk),
        .rst       (rst),
        .lk_valid  (lk_valid),
        .lk_src    (lk_src),
        .tbl_hit   (t_hit),
        .tbl_mcast (t_mcast),
        .tbl_mask  (t_mask),
        .res_valid (res_valid),
        .res_hit   (res_hit),
        .res_mcast (res_mcast),
        .res_mask  (res_mask)
    );

endmodule

// File: rtl/vfdb_engine_chk.sv
module vfdb_engine_chk #(
    parameter int NUM_CHILD = 4,
    parameter int DEPTH     = 8,
    localparam int NP     = NUM_CHILD + 2,
    localparam int SRC_W  = $clog2(NP),
    localparam int UPLINK = NP - 1
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic [47:0]      lk_mac,
    input logic [SRC_W-1:0] lk_src,
    input logic             res_valid,
    input logic             res_hit,
    input logic             res_mcast,
    input logic [NP-1:0]    res_mask,
    input logic             mg_valid,
    input logic [1:0]       mg_cmd,
    input logic [47:0]      mg_mac,
    input logic             mg_mcast,
    input logic [NP-1:0]    mg_mask,
    input logic             mg_done,
    input logic [1:0]       mg_status
);

    p_res_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    p_res_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);

    p_miss_fn_r4: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_src <= SRC_W'(NUM_CHILD))
        |=> (res_hit || res_mask == (NP'(1) << UPLINK)));

    p_miss_up_r5: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_src == SRC_W'(UPLINK))
        |=> (res_hit || res_mask == NP'(1)));

    p_no_src_r6: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_src < SRC_W'(NP)) |=> !res_mask[$past(lk_src)]);

    p_mcast_hit_r3: assert property (@(posedge clk) disable iff (rst)
        res_mcast |-> res_hit);

    p_done_r8: assert property (@(posedge clk) disable iff (rst)
        mg_valid |=> mg_done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !mg_valid |=> (!mg_done && mg_status == 2'd0));

endmodule

bind vfdb_engine vfdb_engine_chk #(.NUM_CHILD(NUM_CHILD), .DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_vfdb_engine.sv
module test_vfdb_engine;

    localparam int NUM_CHILD = 4;
    localparam int DEPTH     = 8;
    localparam int NP        = NUM_CHILD + 2;
    localparam int SRC_W     = $clog2(NP);

    localparam logic [47:0] MAC_A = 48'h0200_0000_00A1;
    localparam logic [47:0] MAC_B = 48'h0200_0000_00B2;
    localparam logic [47:0] MAC_C = 48'h0200_0000_00C3;
    localparam logic [47:0] MAC_M = 48'h0100_5E00_0011;
    localparam logic [47:0] MAC_Q = 48'h0200_0000_0F0F;
    localparam logic [47:0] MAC_E = 48'h0200_0000_EEEE;

    // op: 0 add, 1 modify, 2 delete, 3 lookup
    typedef struct packed {
        logic [1:0]       op;
        logic [47:0]      mac;
        logic             mc;
        logic [NP-1:0]    mask;
        logic [SRC_W-1:0] src;
        logic [1:0]       st;
        logic             hit;
        logic [NP-1:0]    emask;
        logic [3:0]       req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        vec_t'({2'd0, MAC_A, 1'b0, 6'b000010, 3'd0, 2'd0, 1'b0, 6'b000000, 4'd8}),  // R8 add uc
        vec_t'({2'd3, MAC_A, 1'b0, 6'b000000, 3'd0, 2'd0, 1'b1, 6'b000010, 4'd3}),  // R3
        vec_t'({2'd3, MAC_A, 1'b0, 6'b000000, 3'd1, 2'd0, 1'b1, 6'b000000, 4'd6}),  // R6 hairpin
        vec_t'({2'd0, MAC_M, 1'b1, 6'b100101, 3'd0, 2'd0, 1'b0, 6'b000000, 4'd7}),  // R7 add mc
        vec_t'({2'd3, MAC_M, 1'b0, 6'b000000, 3'd2, 2'd0, 1'b1, 6'b100001, 4'd7}),  // R7
        vec_t'({2'd3, MAC_M, 1'b0, 6'b000000, 3'd5, 2'd0, 1'b1, 6'b000101, 4'd7}),  // R7 from uplink
        vec_t'({2'd3, MAC_B, 1'b0, 6'b000000, 3'd3, 2'd0, 1'b0, 6'b100000, 4'd4}),  // R4
        vec_t'({2'd3, MAC_B, 1'b0, 6'b000000, 3'd5, 2'd0, 1'b0, 6'b000001, 4'd5}),  // R5
        vec_t'({2'd0, MAC_A, 1'b0, 6'b000100, 3'd0, 2'd3, 1'b0, 6'b000000, 4'd8}),  // R8 dup
        vec_t'({2'd3, MAC_A, 1'b0, 6'b000000, 3'd0, 2'd0, 1'b1, 6'b000010, 4'd8}),  // R8 unchanged
        vec_t'({2'd1, MAC_A, 1'b0, 6'b001000, 3'd0, 2'd0, 1'b0, 6'b000000, 4'd9}),  // R9
        vec_t'({2'd3, MAC_A, 1'b0, 6'b000000, 3'd0, 2'd0, 1'b1, 6'b001000, 4'd9}),  // R9
        vec_t'({2'd1, MAC_B, 1'b0, 6'b000001, 3'd0, 2'd1, 1'b0, 6'b000000, 4'd9}),  // R9 missing
        vec_t'({2'd0, MAC_C, 1'b0, 6'b000011, 3'd0, 2'd3, 1'b0, 6'b000000, 4'd11}), // R11 uc two
        vec_t'({2'd3, MAC_C, 1'b0, 6'b000000, 3'd0, 2'd0, 1'b0, 6'b100000, 4'd11}), // R11
        vec_t'({2'd0, MAC_C, 1'b1, 6'b000000, 3'd0, 2'd3, 1'b0, 6'b000000, 4'd11}), // R11 mc empty
        vec_t'({2'd2, MAC_A, 1'b0, 6'b000000, 3'd0, 2'd0, 1'b0, 6'b000000, 4'd10}), // R10
        vec_t'({2'd3, MAC_A, 1'b0, 6'b000000, 3'd0, 2'd0, 1'b0, 6'b100000, 4'd10}), // R10
        vec_t'({2'd2, MAC_A, 1'b0, 6'b000000, 3'd0, 2'd1, 1'b0, 6'b000000, 4'd10}), // R10 missing
        vec_t'({2'd3, MAC_A, 1'b0, 6'b000000, 3'd5, 2'd0, 1'b0, 6'b000001, 4'd10})  // R10
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             lk_valid;
    logic [47:0]      lk_mac;
    logic [SRC_W-1:0] lk_src;
    logic             res_valid;
    logic             res_hit;
    logic             res_mcast;
    logic [NP-1:0]    res_mask;
    logic             mg_valid;
    logic [1:0]       mg_cmd;
    logic [47:0]      mg_mac;
    logic             mg_mcast;
    logic [NP-1:0]    mg_mask;
    logic             mg_done;
    logic [1:0]       mg_status;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    vfdb_engine #(.NUM_CHILD(NUM_CHILD), .DEPTH(DEPTH)) i_vfdb_engine (
        .clk (clk), .rst (rst),
        .lk_valid (lk_valid), .lk_mac (lk_mac), .lk_src (lk_src),
        .res_valid (res_valid), .res_hit (res_hit), .res_mcast (res_mcast),
        .res_mask (res_mask),
        .mg_valid (mg_valid), .mg_cmd (mg_cmd), .mg_mac (mg_mac),
        .mg_mcast (mg_mcast), .mg_mask (mg_mask),
        .mg_done (mg_done), .mg_status (mg_status)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one cycle of requests, then sample just after the capturing edge
    task automatic step(input logic lv, input logic [47:0] lm, input logic [SRC_W-1:0] ls,
                        input logic mv, input logic [1:0] mc, input logic [47:0] mm,
                        input logic mt, input logic [NP-1:0] mk);
        @(negedge clk);
        lk_valid = lv; lk_mac = lm; lk_src = ls;
        mg_valid = mv; mg_cmd = mc; mg_mac = mm; mg_mcast = mt; mg_mask = mk;
        @(posedge clk);
        #1;
        lk_valid = 1'b0;
        mg_valid = 1'b0;
    endtask

    task automatic check_lk(input string req, input logic hit, input logic [NP-1:0] m);
        check(res_valid === 1'b1 && res_hit === hit && res_mask === m, req,
              "lookup {valid,hit,mask}",
              64'({res_valid, res_hit, res_mask}), 64'({1'b1, hit, m}));
    endtask

    task automatic check_mg(input string req, input logic [1:0] st);
        check(mg_done === 1'b1 && mg_status === st, req, "command {done,status}",
              64'({mg_done, mg_status}), 64'({1'b1, st}));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        lk_valid = 1'b0; lk_mac = '0; lk_src = '0;
        mg_valid = 1'b0; mg_cmd = '0; mg_mac = '0; mg_mcast = 1'b0; mg_mask = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(res_valid === 1'b0 && res_hit === 1'b0 && res_mcast === 1'b0 && res_mask === '0
              && mg_done === 1'b0 && mg_status === 2'd0, "R1", "reset outputs",
              64'({res_valid, res_hit, res_mcast, res_mask, mg_done, mg_status}), 64'(0));
        @(negedge clk);
        rst = 1'b0;

        // R1 empty table: MAC 0 must miss
        step(1'b1, 48'h0, 3'd0, 1'b0, 2'd0, 48'h0, 1'b0, '0);
        check_lk("R1", 1'b0, 6'b100000);

        // R2 result valid lasts exactly one cycle, result holds
        step(1'b0, 48'h0, 3'd0, 1'b0, 2'd0, 48'h0, 1'b0, '0);
        check(res_valid === 1'b0 && res_mask === 6'b100000, "R2", "idle {valid,mask}",
              64'({res_valid, res_mask}), 64'({1'b0, 6'b100000}));

        for (int i = 0; i < NV; i++) begin
            automatic vec_t v = VECS[i];
            automatic string rq = $sformatf("R%0d", v.req);
            if (v.op == 2'd3) begin
                step(1'b1, v.mac, v.src, 1'b0, 2'd0, 48'h0, 1'b0, '0);
                check_lk(rq, v.hit, v.emask);
            end else begin
                step(1'b0, 48'h0, 3'd0, 1'b1, v.op, v.mac, v.mc, v.mask);
                check_mg(rq, v.st);
            end
        end

        // R3 multicast flag reported on a multicast hit, clear on unicast
        step(1'b1, MAC_M, 3'd0, 1'b0, 2'd0, 48'h0, 1'b0, '0);
        check(res_mcast === 1'b1 && res_hit === 1'b1, "R3", "mcast flag",
              64'({res_mcast, res_hit}), 64'(3));

        // R12 add and lookup of the same MAC in one cycle: lookup sees old (miss)
        step(1'b1, MAC_Q, 3'd0, 1'b1, 2'd0, MAC_Q, 1'b0, 6'b000100);
        check_lk("R12", 1'b0, 6'b100000);
        check_mg("R12", 2'd0);
        step(1'b1, MAC_Q, 3'd0, 1'b0, 2'd0, 48'h0, 1'b0, '0);
        check(res_mcast === 1'b0, "R3", "unicast flag", 64'(res_mcast), 64'(0));
        check_lk("R12", 1'b1, 6'b000100);
        // R12 delete and lookup together: lookup still hits
        step(1'b1, MAC_Q, 3'd0, 1'b1, 2'd2, MAC_Q, 1'b0, '0);
        check_lk("R12", 1'b1, 6'b000100);
        check_mg("R12", 2'd0);
        step(1'b1, MAC_Q, 3'd0, 1'b0, 2'd0, 48'h0, 1'b0, '0);
        check_lk("R12", 1'b0, 6'b100000);

        // R8 fill the table (MAC_M already present), then overflow
        for (int k = 1; k < DEPTH; k++) begin
            step(1'b0, 48'h0, 3'd0, 1'b1, 2'd0, 48'h0200_0000_1000 + 48'(k), 1'b0, 6'b000001);
            check_mg("R8", 2'd0);
        end
        step(1'b0, 48'h0, 3'd0, 1'b1, 2'd0, MAC_E, 1'b0, 6'b000010);
        check_mg("R8", 2'd2);
        step(1'b1, MAC_E, 3'd5, 1'b0, 2'd0, 48'h0, 1'b0, '0);
        check_lk("R8", 1'b0, 6'b000001);
        step(1'b1, 48'h0200_0000_1000 + 48'(DEPTH - 1), 3'd5, 1'b0, 2'd0, 48'h0, 1'b0, '0);
        check_lk("R8", 1'b1, 6'b000001);

        // R8 reserved command rejected and leaves the rule intact
        step(1'b0, 48'h0, 3'd0, 1'b1, 2'd3, MAC_M, 1'b0, '0);
        check_mg("R8", 2'd3);
        step(1'b1, MAC_M, 3'd4, 1'b0, 2'd0, 48'h0, 1'b0, '0);
        check_lk("R8", 1'b1, 6'b100101);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule